// File: doc/BRIEF.md
# Burst Address Generator

This block produces the address for a memory that is read or written in bursts of four beats. A burst starts when either of two start strobes is high at a rising clock edge. One strobe comes from the processor side and the other from the memory controller side. On that edge the block captures the external address. After that it steps the two least significant address bits with an internal two-bit beat counter. The counter moves forward only on edges where the advance input is high.

The stepping order depends on a static mode pin that is not registered. In linear order the low bits count up from the captured value and wrap modulo four. In interleaved order the low bits are the captured low bits XORed with the beat number. The upper address bits stay fixed for the whole burst. A wrap flag marks the fourth beat of a burst. The memory array, write control and chip-enable decode sit outside this block.

Top module: `burst_addr_gen`

## Requirements
- R1: While `rst_n` is low at a rising edge, the next `addr_q` is 0 and the next `burst_last` is 0.
- R2: When `start_cpu` or `start_ctl` is 1 at a rising edge, `addr_q` equals the `addr_d` sampled at that edge from the following cycle on. This first beat is the same in both orders.
- R3: With `order_ilv` = 0, each rising edge with `step` = 1 and no start strobe advances the beat count by one. `addr_q[1:0]` equals the captured low bits plus the beat count, modulo 4. For example, a start of 2 gives 2,3,0,1.
- R4: With `order_ilv` = 1, `addr_q[1:0]` equals the captured low bits XOR the beat count. For example, a start of 1 gives 1,0,3,2.
- R5: `order_ilv` is combinational. A change on it alters `addr_q[1:0]` within the same clock cycle, with no clock edge needed.
- R6: `addr_q[14:2]` changes only at an edge where a start strobe is 1. Advances never alter it.
- R7: A start strobe wins over `step` in the same cycle. The burst restarts at beat 0 with the new address.
- R8: When neither start strobe nor `step` is 1 at an edge, `addr_q` and `burst_last` keep their values.
- R9: `burst_last` is 1 exactly while the beat count is 3, which is the fourth beat. One more advance returns to beat 0, the first address of the burst.
- R10: Both start strobes high together load `addr_d` once, exactly as a single strobe would.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_d | input | 15 | External address captured at burst start |
| start_cpu | input | 1 | Processor-side burst start strobe, active high |
| start_ctl | input | 1 | Controller-side burst start strobe, active high |
| step | input | 1 | Advance the beat counter, active high |
| order_ilv | input | 1 | Burst order: 0 linear, 1 interleaved (unregistered) |
| addr_q | output | 15 | Current burst address |
| burst_last | output | 1 | High on the fourth beat of a burst |

## Verification
The only state in this block is the captured base address and the two-bit beat count. Both are visible at `addr_q` in the cycle after the edge that set them. A wrong base shows at once on the first beat after a strobe. A wrong beat count shows on the next advance as a wrong low pair, or as `burst_last` on the wrong beat. An upper-bit fault can hide until an advance, so the bench runs full bursts of four or more beats in both orders. It also toggles the order pin mid-burst to expose any hidden registering of that pin.

// File: rtl/burst_addr_pkg.sv
// Package: shared types for the burst address generator.
// Assumes: the beat counter width is passed as a parameter to each user.
package burst_addr_pkg;

    // Burst ordering selected by the static mode pin
    typedef enum logic {
        ORDER_LINEAR      = 1'b0,
        ORDER_INTERLEAVED = 1'b1
    } burst_order_e;

    // Per-edge action of the sequencer
    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_STEP = 2'd1,
        ACT_LOAD = 2'd2
    } burst_act_e;

    // Resolve start strobes and advance into one action; a start wins
    function automatic burst_act_e decode_act(input logic s_a, input logic s_b,
                                              input logic adv);
        if (s_a || s_b)
            return ACT_LOAD;
        else if (adv)
            return ACT_STEP;
        else
            return ACT_HOLD;
    endfunction

endpackage

// File: rtl/bag_beat_counter.sv
// Module: beat counter of a burst.
// Clears to zero on a load, increments on a step, and wraps modulo 2**BEAT_W.
// Flags the final beat of the burst.
// Assumes: act is already resolved with load taking priority.
module bag_beat_counter
    import burst_addr_pkg::*;
#(
    parameter int unsigned BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  burst_act_e        act,
    output logic [BEAT_W-1:0] beat,
    output logic              last_beat
);
    localparam logic [BEAT_W-1:0] BEAT_ONE  = BEAT_W'(1);
    localparam logic [BEAT_W-1:0] BEAT_LAST = {BEAT_W{1'b1}};

    logic [BEAT_W-1:0] beat_r;

    // Beat register: reset, clear on load, step modulo burst length
    always_ff @(posedge clk) begin
        if (!rst_n)
            beat_r <= '0;
        else begin
            case (act)
                ACT_LOAD: beat_r <= '0;
                ACT_STEP: beat_r <= beat_r + BEAT_ONE;
                default:  beat_r <= beat_r;
            endcase
        end
    end

    // Final-beat flag from the current count
    always_comb begin
        last_beat = (beat_r == BEAT_LAST);
    end

    assign beat = beat_r;
endmodule

// File: rtl/bag_base_reg.sv
// Module: holds the address captured at the start of a burst.
// Assumes: load is a single-cycle decision made at the clock edge.
module bag_base_reg #(
    parameter int unsigned ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] base
);
    logic [ADDR_W-1:0] base_r;

    // Base capture: reset to zero, take the new address on load
    always_ff @(posedge clk) begin
        if (!rst_n)
            base_r <= '0;
        else if (load)
            base_r <= addr_in;
    end

    assign base = base_r;
endmodule

// File: rtl/bag_order_map.sv
// Module: maps base low bits and the beat count to the current low bits.
// The map is either a modulo add (linear) or a bitwise XOR (interleaved).
// Assumes: the order pin is static during normal use, but the map is purely
// combinational, so a change on it takes effect at once.
module bag_order_map
    import burst_addr_pkg::*;
#(
    parameter int unsigned BEAT_W = 2
) (
    input  logic [BEAT_W-1:0] base_lo,
    input  logic [BEAT_W-1:0] beat,
    input  burst_order_e      order,
    output logic [BEAT_W-1:0] lo_out
);
    logic [BEAT_W-1:0] lin_lo;
    logic [BEAT_W-1:0] ilv_lo;

    // Linear candidate: add with natural modulo wrap
    always_comb begin
        lin_lo = base_lo + beat;
    end

    // Interleaved candidate: one XOR per bit
    for (genvar g = 0; g < BEAT_W; g++) begin : g_ilv_bit
        assign ilv_lo[g] = base_lo[g] ^ beat[g];
    end

    // Order select, unregistered
    always_comb begin
        lo_out = (order == ORDER_INTERLEAVED) ? ilv_lo : lin_lo;
    end
endmodule

// File: rtl/burst_addr_gen.sv
// Module: burst address generator (top).
// Captures the external address on either start strobe. Steps the low
// BEAT_W bits by the beat counter on each advance, in linear or interleaved
// order, and flags the final beat.
// Assumes: all controls except order_ilv are sampled at the rising edge.
module burst_addr_gen
    import burst_addr_pkg::*;
#(
    parameter int unsigned ADDR_W = 15,
    parameter int unsigned BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_d,
    input  logic              start_cpu,
    input  logic              start_ctl,
    input  logic              step,
    input  logic              order_ilv,
    output logic [ADDR_W-1:0] addr_q,
    output logic              burst_last
);
    localparam int unsigned UPPER_W = ADDR_W - BEAT_W;

    burst_act_e        act;
    burst_order_e      order;
    logic [ADDR_W-1:0] base;
    logic [BEAT_W-1:0] beat;
    logic [BEAT_W-1:0] lo_bits;

    // Resolve controls for this edge
    always_comb begin
        act   = decode_act(start_cpu, start_ctl, step);
        order = burst_order_e'(order_ilv);
    end

    bag_base_reg #(.ADDR_W(ADDR_W)) base_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (act == ACT_LOAD),
        .addr_in (addr_d),
        .base    (base)
    );

    bag_beat_counter #(.BEAT_W(BEAT_W)) beat_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .act       (act),
        .beat      (beat),
        .last_beat (burst_last)
    );

    bag_order_map #(.BEAT_W(BEAT_W)) map_i (
        .base_lo (base[BEAT_W-1:0]),
        .beat    (beat),
        .order   (order),
        .lo_out  (lo_bits)
    );

    // Output address: fixed upper part with the sequenced low bits
    always_comb begin
        addr_q = {base[ADDR_W-1 -: UPPER_W], lo_bits};
    end
endmodule

// File: rtl/burst_addr_gen_chk.sv
// Checker: port-level properties of the burst address generator.
// Assumes: bound to every burst_addr_gen instance.
module burst_addr_gen_chk #(
    parameter int unsigned ADDR_W = 15,
    parameter int unsigned BEAT_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr_d,
    input logic              start_cpu,
    input logic              start_ctl,
    input logic              step,
    input logic              order_ilv,
    input logic [ADDR_W-1:0] addr_q,
    input logic              burst_last
);
    localparam logic [BEAT_W-1:0] LO_ONE = BEAT_W'(1);

    logic strb;
    assign strb = start_cpu | start_ctl;

    AST_LOAD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        strb |=> addr_q == $past(addr_d)); // R2

    AST_LOAD_NOT_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        strb |=> !burst_last); // R7

    AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (!strb && $past(rst_n)) |=> $stable(addr_q[ADDR_W-1:BEAT_W])); // R6

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!strb && !step && $past(rst_n)) |=>
            (order_ilv != $past(order_ilv)) || ($stable(addr_q) && $stable(burst_last))); // R8

    AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!strb && step && !order_ilv && $past(rst_n)) |=>
            order_ilv || (addr_q[BEAT_W-1:0] == $past(addr_q[BEAT_W-1:0]) + LO_ONE)); // R3

    AST_LAST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_last && step && !strb && $past(rst_n)) |=> !burst_last); // R9
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr_d     (addr_d),
    .start_cpu  (start_cpu),
    .start_ctl  (start_ctl),
    .step       (step),
    .order_ilv  (order_ilv),
    .addr_q     (addr_q),
    .burst_last (burst_last)
);

// File: tb/burst_addr_gen_tb_top.sv
// Directed bench for burst_addr_gen; one task per scenario.
module burst_addr_gen_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [14:0] addr_d = '0;
    logic        start_cpu = 1'b0;
    logic        start_ctl = 1'b0;
    logic        step = 1'b0;
    logic        order_ilv = 1'b0;
    logic [14:0] addr_q;
    logic        burst_last;

    int checks = 0;
    int errors = 0;
    logic [14:0] m_base = '0;
    logic [1:0]  m_beat = '0;

    always #10 clk = ~clk;

    burst_addr_gen dut_i (
        .clk(clk), .rst_n(rst_n), .addr_d(addr_d), .start_cpu(start_cpu),
        .start_ctl(start_ctl), .step(step), .order_ilv(order_ilv),
        .addr_q(addr_q), .burst_last(burst_last)
    );

    function automatic logic [14:0] exp_addr();
        logic [1:0] lo;
        lo = order_ilv ? (m_base[1:0] ^ m_beat) : (m_base[1:0] + m_beat);
        return {m_base[14:2], lo};
    endfunction

    task automatic check(input string req, input logic [14:0] got, input logic [14:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    task automatic check_out(input string req);
        check(req, addr_q, exp_addr());
        check(req, {14'd0, burst_last}, {14'd0, m_beat == 2'd3});
    endtask

    // One edge with given controls; model updated from the requirements
    task automatic edge_do(input logic sc, input logic sk, input logic ad,
                           input logic [14:0] a);
        start_cpu = sc; start_ctl = sk; step = ad; addr_d = a;
        @(posedge clk);
        if (sc || sk) begin m_base = a; m_beat = 2'd0; end
        else if (ad) m_beat = m_beat + 2'd1;
        #5;
        start_cpu = 1'b0; start_ctl = 1'b0; step = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #5;
        m_base = '0; m_beat = '0;
        check("R1", addr_q, 15'd0);
        check("R1", {14'd0, burst_last}, 15'd0);
        rst_n = 1'b1;
    endtask

    task automatic t_linear();
        order_ilv = 1'b0;
        edge_do(1'b1, 1'b0, 1'b0, 15'h5A6E);
        check_out("R2");
        check("R2", addr_q, 15'h5A6E);
        for (int i = 0; i < 4; i++) begin
            edge_do(1'b0, 1'b0, 1'b1, 15'h0);
            check_out("R3");
            check("R6", {addr_q[14:2], 2'b00}, 15'h5A6C);
        end
        check("R9", addr_q, 15'h5A6E);
    endtask

    task automatic t_interleaved();
        logic [1:0] seq [4];
        seq[0] = 2'd1; seq[1] = 2'd0; seq[2] = 2'd3; seq[3] = 2'd2;
        order_ilv = 1'b1;
        edge_do(1'b0, 1'b1, 1'b0, 15'h1231);
        for (int i = 0; i < 4; i++) begin
            check("R4", {13'd0, addr_q[1:0]}, {13'd0, seq[i]});
            check_out("R4");
            if (i == 3) check("R9", {14'd0, burst_last}, 15'd1);
            edge_do(1'b0, 1'b0, 1'b1, 15'h0);
        end
        check("R9", {14'd0, burst_last}, 15'd0);
    endtask

    task automatic t_order_switch();
        order_ilv = 1'b0;
        edge_do(1'b1, 1'b0, 1'b0, 15'h0003);
        edge_do(1'b0, 1'b0, 1'b1, 15'h0);
        check("R5", addr_q, 15'h0000);
        #2 order_ilv = 1'b1;
        #1 check("R5", addr_q, 15'h0002);
        order_ilv = 1'b0;
        #1 check_out("R5");
    endtask

    task automatic t_priority();
        order_ilv = 1'b0;
        edge_do(1'b1, 1'b0, 1'b0, 15'h2220);
        edge_do(1'b0, 1'b0, 1'b1, 15'h0);
        edge_do(1'b0, 1'b1, 1'b1, 15'h7FF5);
        check("R7", addr_q, 15'h7FF5);
        check_out("R7");
    endtask

    task automatic t_hold();
        order_ilv = 1'b1;
        edge_do(1'b1, 1'b0, 1'b0, 15'h4002);
        edge_do(1'b0, 1'b0, 1'b1, 15'h0);
        for (int i = 0; i < 3; i++) begin
            edge_do(1'b0, 1'b0, 1'b0, 15'h3FFF);
            check("R8", addr_q, 15'h4003);
            check_out("R8");
        end
    endtask

    task automatic t_both_strobes();
        order_ilv = 1'b0;
        edge_do(1'b1, 1'b1, 1'b0, 15'h0ABD);
        check("R10", addr_q, 15'h0ABD);
        edge_do(1'b0, 1'b0, 1'b1, 15'h0);
        check("R10", addr_q, 15'h0ABE);
        check_out("R10");
    endtask

    initial begin
        t_reset();
        t_linear();
        t_interleaved();
        t_order_switch();
        t_priority();
        t_hold();
        t_both_strobes();
        t_reset();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired got timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule